// File: doc/BRIEF.md
# Byte-Order-Selectable Transmit Word Queue

This block is the transmit-side buffer of one network port. A host deposits 32-bit words into it one per clock, and a byte-wide serial transmitter drains it one byte per handshake. Each stored word is split into four bytes on the way out. A mode input chooses which end of the word leaves first, so hosts of either byte-order convention can feed the same transmitter.

A programmable threshold, counted in whole words, governs two level flags. The space flag tells the host that at least that many word slots are free. The data flag tells a consumer that at least that many words are waiting. Two sticky error flags record a write that arrived when every slot was taken, and a byte request from the transmitter that found nothing to send while a packet was in progress. An active-low reset empties the queue and clears both sticky flags.

Top module: `txq_endian_fifo`

## Requirements
- R1: After reset, byte_valid, data_ok, overflow and underflow are 0 and space_ok is 1.
- R2: With big_endian = 0, a word leaves as bits 7:0 first, then 15:8, then 23:16, then 31:24.
- R3: With big_endian = 1, a word leaves as bits 31:24 first, then 23:16, then 15:8, then 7:0. The mode applies when each byte is presented, not when the word is written.
- R4: Words leave in the order they were accepted, and the queue holds 32 words.
- R5: space_ok is 1 exactly when the free word slots are at least the effective threshold. The effective threshold is the 4-bit thresh input, or 1 when thresh is 0.
- R6: data_ok is 1 exactly when the number of stored words is at least the effective threshold.
- R7: A write while 32 words are stored is discarded and sets overflow, which stays 1 until reset.
- R8: byte_ready high while byte_valid is low and pkt_active is high sets underflow, which stays 1 until reset. The same request with pkt_active low leaves underflow at 0.
- R9: A byte moves on a clock edge where byte_valid and byte_ready are both high. byte_data holds while byte_ready is low. A word counts as stored until its fourth byte has moved.
- R10: Reset in mid-operation discards all stored words and clears both sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| big_endian | input | 1 | 1: most significant byte leaves first |
| thresh | input | 4 | Threshold in words, 0 treated as 1 |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| space_ok | output | 1 | Free slots at least the threshold |
| data_ok | output | 1 | Stored words at least the threshold |
| byte_valid | output | 1 | A byte is presented |
| byte_data | output | 8 | Presented byte |
| byte_ready | input | 1 | Transmitter takes the byte |
| pkt_active | input | 1 | Transmitter is inside a packet |
| overflow | output | 1 | Sticky: write was dropped |
| underflow | output | 1 | Sticky: byte requested while empty in a packet |

## Verification
The bench fills the queue up to the 32nd word and then writes once more. A design that accepted that extra word would either corrupt the head or emit an unexpected fifth group of bytes, and the scoreboard would catch either. The threshold flags are probed one word either side of the boundary, and also with a zero threshold. A flag built with a strict comparison, or one that took zero literally, would be wrong at exactly those points. Byte order is checked in both modes. A stalled word is drained one byte at a time, which exposes a lane counter that advances without a handshake or a word that is released before its last byte. Underflow is provoked both inside and outside a packet, so a flag that ignores pkt_active would set when it should not.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int unsigned LANES = 4;

    typedef enum logic {
        ORD_LOW_FIRST  = 1'b0,
        ORD_HIGH_FIRST = 1'b1
    } byte_order_e;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned PW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head_data,
    output logic [CW-1:0]     count,
    output logic              full
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CW'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        if (push_ok)
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (pop_ok)
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            st_q <= st_d;
            if (push_ok) mem_q[st_q.wr] <= push_data;
        end
    end

    assign head_data = mem_q[st_q.rd];
    assign count     = st_q.cnt;
    assign full      = (st_q.cnt == CW'(DEPTH));

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> $stable(count));
endmodule

// File: rtl/txq_serial.sv
module txq_serial
    import txq_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned LW    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic [WORD_W-1:0] head_data,
    input  logic              have_word,
    input  logic              byte_ready,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              pop
);
    logic [BYTE_W-1:0] lanes [LANES];
    logic [LW-1:0] lane_d, lane_q, sel;
    logic fire;
    byte_order_e order;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = head_data[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        order  = byte_order_e'(big_endian);
        fire   = have_word && byte_ready;
        pop    = fire && (lane_q == LW'(LANES - 1));
        lane_d = lane_q;
        if (fire) lane_d = pop ? '0 : lane_q + 1'b1;
        sel = (order == ORD_HIGH_FIRST) ? LW'(LANES - 1) - lane_q : lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign byte_valid = have_word;
    assign byte_data  = lanes[sel];

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready |=> byte_valid);
    assert_pop_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> byte_valid && byte_ready);
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned THR_W = 4,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    count,
    input  logic [THR_W-1:0] thresh,
    input  logic             wr_en,
    input  logic             full,
    input  logic             pkt_active,
    input  logic             byte_ready,
    input  logic             byte_valid,
    output logic             space_ok,
    output logic             data_ok,
    output logic             overflow,
    output logic             underflow
);
    typedef struct packed {
        logic ovf;
        logic unf;
    } sticky_t;

    sticky_t stk_d, stk_q;
    logic [CW-1:0] thr_eff, free_slots;

    always_comb begin
        thr_eff    = (thresh == '0) ? CW'(1) : CW'(thresh);
        free_slots = CW'(DEPTH) - count;
        stk_d      = stk_q;
        if (wr_en && full) stk_d.ovf = 1'b1;
        if (pkt_active && byte_ready && !byte_valid) stk_d.unf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign space_ok  = (free_slots >= thr_eff);
    assign data_ok   = (count >= thr_eff);
    assign overflow  = stk_q.ovf;
    assign underflow = stk_q.unf;

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_underflow_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_active && byte_ready && !byte_valid |=> underflow);
    assert_full_no_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !space_ok);
endmodule

// File: rtl/txq_endian_fifo.sv
module txq_endian_fifo #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned THR_W  = 4,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic [THR_W-1:0]  thresh,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              space_ok,
    output logic              data_ok,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    input  logic              byte_ready,
    input  logic              pkt_active,
    output logic              overflow,
    output logic              underflow
);
    logic [WORD_W-1:0] head;
    logic [CW-1:0] count;
    logic full, pop, have_word;

    assign have_word = (count != '0);

    txq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(pop), .head_data(head), .count(count), .full(full)
    );

    txq_serial #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .head_data(head),
        .have_word(have_word), .byte_ready(byte_ready),
        .byte_valid(byte_valid), .byte_data(byte_data), .pop(pop)
    );

    txq_flags #(.DEPTH(DEPTH), .THR_W(THR_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .count(count), .thresh(thresh),
        .wr_en(wr_en), .full(full), .pkt_active(pkt_active),
        .byte_ready(byte_ready), .byte_valid(byte_valid),
        .space_ok(space_ok), .data_ok(data_ok),
        .overflow(overflow), .underflow(underflow)
    );
endmodule

// File: tb/sim_txq_endian_fifo.sv
module sim_txq_endian_fifo;
    localparam int PERIOD = 10;

    logic clk = 0, rst_n = 0, big_endian = 0, wr_en = 0;
    logic byte_ready = 0, pkt_active = 0;
    logic [3:0] thresh = 4'd1;
    logic [31:0] wr_data = '0;
    logic space_ok, data_ok, byte_valid, overflow, underflow;
    logic [7:0] byte_data;

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #(PERIOD/2) clk = ~clk;

    txq_endian_fifo u0 (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .thresh(thresh),
        .wr_en(wr_en), .wr_data(wr_data), .space_ok(space_ok), .data_ok(data_ok),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .pkt_active(pkt_active), .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 0; exp_q.delete(); tag_q.delete();
        tick(); tick();
        rst_n = 1; tick();
    endtask

    // driver: expected bytes follow the mode that will be in force when drained
    task automatic write_word(input logic [31:0] w, input bit dropped);
        wr_en = 1; wr_data = w;
        if (!dropped) begin
            for (int k = 0; k < 4; k++) begin
                exp_q.push_back(big_endian ? w[(3-k)*8 +: 8] : w[k*8 +: 8]);
                tag_q.push_back(big_endian ? "R3 order" : "R2 order");
            end
        end
        tick();
        wr_en = 0;
    endtask

    task automatic drain();
        byte_ready = 1;
        for (int n = 0; n < 400 && exp_q.size() != 0; n++) tick();
        tick();
        byte_ready = 0;
        chk(exp_q.size() == 0, "R4 all bytes out", exp_q.size(), 0);
        chk(byte_valid == 0, "R4 queue empty after drain", byte_valid, 0);
    endtask

    // monitor: compare each transferred byte against the scoreboard
    always @(negedge clk) begin
        if (rst_n && byte_valid && byte_ready) begin
            if (exp_q.size() == 0) chk(0, "R4 unexpected byte", byte_data, 0);
            else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(byte_data == e, t, byte_data, e);
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        chk(0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1
        chk(byte_valid == 0, "R1 byte_valid", byte_valid, 0);
        chk(space_ok == 1, "R1 space_ok", space_ok, 1);
        chk(data_ok == 0, "R1 data_ok", data_ok, 0);
        chk(overflow == 0 && underflow == 0, "R1 sticky", {overflow, underflow}, 0);

        // R2 little-endian, R6 data threshold
        big_endian = 0;
        write_word(32'h0403_0201, 0);
        write_word(32'h8877_6655, 0);
        write_word(32'hDEAD_BEEF, 0);
        thresh = 4'd2; #1;
        chk(data_ok == 1, "R6 3 words thr2", data_ok, 1);
        thresh = 4'd4; #1;
        chk(data_ok == 0, "R6 3 words thr4", data_ok, 0);
        thresh = 4'd3; #1;
        chk(data_ok == 1, "R6 3 words thr3", data_ok, 1);
        drain();

        // R3 big-endian
        big_endian = 1;
        write_word(32'h1122_3344, 0);
        write_word(32'hA5B6_C7D8, 0);
        drain();

        // R5 space threshold and R7 overflow, with full depth
        big_endian = 0; thresh = 4'd15;
        for (int i = 0; i < 17; i++) write_word(32'h1000_0000 + i * 32'h0101_0101, 0);
        chk(space_ok == 1, "R5 free 15 thr15", space_ok, 1);
        chk(data_ok == 1, "R6 17 words thr15", data_ok, 1);
        write_word(32'h2222_2222, 0);
        chk(space_ok == 0, "R5 free 14 thr15", space_ok, 0);
        thresh = 4'd0; #1;
        chk(space_ok == 1, "R5 thr0 as one", space_ok, 1);
        for (int i = 0; i < 13; i++) write_word(32'h3000_0000 + i, 0);
        chk(space_ok == 1, "R5 free 1 thr0", space_ok, 1);
        write_word(32'h4444_4444, 0);
        chk(space_ok == 0, "R5 full thr0", space_ok, 0);
        chk(overflow == 0, "R7 no overflow yet", overflow, 0);
        write_word(32'hBAD0_BAD0, 1);
        chk(overflow == 1, "R7 overflow set", overflow, 1);
        drain();
        chk(overflow == 1, "R7 overflow sticky", overflow, 1);

        // R9 stall and word release only after its last byte
        do_reset();
        thresh = 4'd1;
        write_word(32'h1122_3344, 0);
        tick(); tick();
        chk(byte_valid == 1 && byte_data == 8'h44, "R9 held first byte", byte_data, 8'h44);
        byte_ready = 1; tick(); byte_ready = 0;
        chk(byte_data == 8'h33, "R9 next byte", byte_data, 8'h33);
        tick();
        chk(byte_data == 8'h33, "R9 stalled byte", byte_data, 8'h33);
        byte_ready = 1; tick(); tick(); byte_ready = 0;
        chk(data_ok == 1 && byte_valid == 1, "R9 word kept until last byte", data_ok, 1);
        byte_ready = 1; tick(); byte_ready = 0;
        chk(data_ok == 0 && byte_valid == 0, "R9 word released", data_ok, 0);

        // R8 underflow
        byte_ready = 1; pkt_active = 0;
        tick(); tick(); tick();
        chk(underflow == 0, "R8 idle request outside packet", underflow, 0);
        pkt_active = 1; tick(); pkt_active = 0;
        chk(underflow == 1, "R8 underflow set", underflow, 1);
        tick(); tick();
        chk(underflow == 1, "R8 underflow sticky", underflow, 1);
        byte_ready = 0;

        // R10 reset mid-operation
        write_word(32'h5555_5555, 0);
        write_word(32'h6666_6666, 0);
        do_reset();
        chk(byte_valid == 0 && data_ok == 0, "R10 contents cleared", {byte_valid, data_ok}, 0);
        chk(space_ok == 1 && overflow == 0 && underflow == 0, "R10 flags cleared",
            {space_ok, overflow, underflow}, 3'b100);
        write_word(32'hCAFE_F00D, 0);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule